// File: doc/BRIEF.md
# Raster Sync Timing Generator

This block produces the horizontal sync, vertical sync and data-enable signals for a raster display. It advances one pixel position on each cycle where the pixel-clock enable is high. Horizontal timing is counted in pixel clocks. Vertical timing is counted in whole line periods. Every timing field is programmed as its real value minus one. Each line has four phases in this order: sync pulse, back porch, active pixels, and a front porch that uses up the rest of the programmed period. Frames follow the same order, counted in lines.

Software raises the display-enable input to scan one frame. With continuous mode set, frames repeat back to back until the enable is dropped. The block drives a busy status and a one-clock end-of-frame pulse. It also outputs the current pixel and line coordinates for a downstream fetch unit. Three interlace variants choose which picture lines each field carries. The block samples all configuration at each frame start, so writes made during a frame only affect the next frame.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset the block is idle. busy=0, eof=0, de=0, and hsync=1 and vsync=1 (inactive levels with all polarity bits clear).
- R2: A line lasts h_total_m1+1 pixel clocks. The horizontal sync is active for the first h_sw_m1+1 of them. Then come h_bp_m1+1 back-porch clocks, and then act_w_m1+1 active pixels.
- R3: A frame lasts v_total_m1+1 lines. The vertical sync is active for the first v_sw_m1+1 whole lines. Then come v_bp_m1+1 back-porch lines, and after them the active lines begin. busy stays high for the full frame.
- R4: de is asserted only on active pixels of active lines. pix_x counts 0..act_w_m1 across the line. line_y gives the picture line. Both coordinates read 0 when de is not asserted.
- R5: With its polarity bit clear, hsync and vsync are active low and de is active high. Setting hs_inv, vs_inv or de_inv inverts that single output, in both its active and its inactive level.
- R6: eof is a pulse one clock wide. It appears in the pixel slot right after the last active pixel of the last active line of the frame, once per frame.
- R7: A rising edge on disp_en starts a frame from idle. Without cont_mode the block returns to idle after that one frame, even while disp_en stays high.
- R8: With cont_mode=1 and disp_en held high, frames run back to back with no idle gap. After disp_en is dropped, the current frame completes and the block goes idle.
- R9: ilace_mode selects the interlace variant. 00 progressive: line_y = row. 10 even field only: line_y = 2*row. 11 odd field only: line_y = 2*row+1. 01 alternating fields: the first frame after a start from idle is even, and each following back-to-back frame toggles. The field output shows the current field (1 = odd). A row is active only while line_y <= act_h_m1.
- R10: All configuration inputs are captured at frame start. Changes made during a frame do not alter that frame and take effect from the next one.
- R11: Counters advance only on clocks with pix_ce=1, so every pixel slot lasts as many clocks as pix_ce takes to pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_ce | input | 1 | Pixel-clock enable |
| disp_en | input | 1 | Display enable; a rising edge starts scanning |
| cont_mode | input | 1 | Continuous frame operation |
| act_w_m1 | input | 11 | Active width minus one |
| act_h_m1 | input | 11 | Active height minus one |
| h_total_m1 | input | 12 | Line period minus one, pixel clocks |
| h_bp_m1 | input | 8 | Horizontal back porch minus one |
| h_sw_m1 | input | 8 | Horizontal sync width minus one |
| v_total_m1 | input | 12 | Frame period minus one, lines |
| v_bp_m1 | input | 8 | Vertical back porch minus one, lines |
| v_sw_m1 | input | 8 | Vertical sync width minus one, lines |
| hs_inv | input | 1 | Invert hsync |
| vs_inv | input | 1 | Invert vsync |
| de_inv | input | 1 | Invert de |
| ilace_mode | input | 2 | Interlace variant |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| busy | output | 1 | Scanning or generating syncs |
| eof | output | 1 | End-of-frame pulse |
| field | output | 1 | Current field, 1 = odd |
| pix_x | output | 11 | Active pixel column |
| line_y | output | 11 | Active picture line |

## Verification
The hardest behaviour to reach is at the frame boundary, where three things are decided in one slot: whether to run another frame, which field comes next, and which configuration to load. These cases only show up across back-to-back frames. The stimulus therefore holds disp_en high in continuous mode for two or three frames. It changes the active width in mid-frame and drops disp_en partway through a later frame. It then checks per-frame counts of de, eof and busy against the old and new settings. Alternating-field interlace is run for two consecutive frames, and the line numbers and field flag of each frame are compared.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
    // Interlace variant encoding, as seen on ilace_mode
    typedef enum logic [1:0] {
        IL_PROG = 2'b00,
        IL_ALT  = 2'b01,
        IL_EVEN = 2'b10,
        IL_ODD  = 2'b11
    } ilace_e;
endpackage

// File: rtl/dtg_axis_decode.sv
// Decodes one axis counter into sync / active window and active offset.
module dtg_axis_decode #(
    parameter int CNT_W = 12,
    parameter int PW_W  = 8,
    parameter int EXT_W = 11
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [PW_W-1:0]  sync_m1,
    input  logic [PW_W-1:0]  porch_m1,
    input  logic [EXT_W-1:0] ext_m1,
    output logic             in_sync,
    output logic             in_act,
    output logic [EXT_W-1:0] offset
);
    localparam int BASE_W = (CNT_W > EXT_W) ? CNT_W : EXT_W;
    localparam int SUM_W  = ((BASE_W > PW_W) ? BASE_W : PW_W) + 2;

    logic [SUM_W-1:0] cnt_e;
    logic [SUM_W-1:0] start_e;
    logic [SUM_W-1:0] stop_e;

    always_comb begin
        cnt_e   = SUM_W'(cnt);
        start_e = SUM_W'(sync_m1) + SUM_W'(porch_m1) + SUM_W'(2);
        stop_e  = start_e + SUM_W'(ext_m1);
        in_sync = cnt_e <= SUM_W'(sync_m1);
        in_act  = (cnt_e >= start_e) && (cnt_e <= stop_e);
        offset  = EXT_W'(cnt_e - start_e);
    end
endmodule

// File: rtl/dtg_out_pol.sv
// Output stage: maps raw active flags to pin levels with per-pin inversion.
module dtg_out_pol #(
    parameter int N = 3
) (
    input  logic [N-1:0] act,
    input  logic [N-1:0] act_level,
    input  logic [N-1:0] inv,
    output logic [N-1:0] level
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        assign level[g] = (act[g] ? act_level[g] : ~act_level[g]) ^ inv[g];
    end
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
    import dtg_pkg::*;
#(
    parameter int DIM_W = 11,
    parameter int PER_W = 12,
    parameter int PW_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_ce,
    input  logic             disp_en,
    input  logic             cont_mode,
    input  logic [DIM_W-1:0] act_w_m1,
    input  logic [DIM_W-1:0] act_h_m1,
    input  logic [PER_W-1:0] h_total_m1,
    input  logic [PW_W-1:0]  h_bp_m1,
    input  logic [PW_W-1:0]  h_sw_m1,
    input  logic [PER_W-1:0] v_total_m1,
    input  logic [PW_W-1:0]  v_bp_m1,
    input  logic [PW_W-1:0]  v_sw_m1,
    input  logic             hs_inv,
    input  logic             vs_inv,
    input  logic             de_inv,
    input  logic [1:0]       ilace_mode,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic             busy,
    output logic             eof,
    output logic             field,
    output logic [DIM_W-1:0] pix_x,
    output logic [DIM_W-1:0] line_y
);
    localparam int LN_W = DIM_W + 1;  // line number incl. field bit
    localparam int CMP_W = DIM_W + 2; // room for line + step

    typedef struct packed {
        logic [DIM_W-1:0] act_w;
        logic [DIM_W-1:0] act_h;
        logic [PER_W-1:0] h_tot;
        logic [PER_W-1:0] v_tot;
        logic [PW_W-1:0]  h_bp;
        logic [PW_W-1:0]  h_sw;
        logic [PW_W-1:0]  v_bp;
        logic [PW_W-1:0]  v_sw;
        logic             hs_inv;
        logic             vs_inv;
        logic             de_inv;
        ilace_e           ilace;
    } cfg_t;

    typedef struct packed {
        logic             run;
        logic [PER_W-1:0] hc;
        logic [PER_W-1:0] vc;
        logic             field;
        logic             en_prev;
        logic             req;
        logic             eof;
        cfg_t             cfg;
    } st_t;

    st_t  st_q, st_d;
    cfg_t cfg_in;

    always_comb begin
        cfg_in.act_w  = act_w_m1;
        cfg_in.act_h  = act_h_m1;
        cfg_in.h_tot  = h_total_m1;
        cfg_in.v_tot  = v_total_m1;
        cfg_in.h_bp   = h_bp_m1;
        cfg_in.h_sw   = h_sw_m1;
        cfg_in.v_bp   = v_bp_m1;
        cfg_in.v_sw   = v_sw_m1;
        cfg_in.hs_inv = hs_inv;
        cfg_in.vs_inv = vs_inv;
        cfg_in.de_inv = de_inv;
        cfg_in.ilace  = ilace_e'(ilace_mode);
    end

    // ---------------- axis decode ----------------
    logic             h_sync, h_act, v_sync, v_win;
    logic [DIM_W-1:0] h_off, v_row;

    dtg_axis_decode #(.CNT_W(PER_W), .PW_W(PW_W), .EXT_W(DIM_W)) u_hdec (
        .cnt     (st_q.hc),
        .sync_m1 (st_q.cfg.h_sw),
        .porch_m1(st_q.cfg.h_bp),
        .ext_m1  (st_q.cfg.act_w),
        .in_sync (h_sync),
        .in_act  (h_act),
        .offset  (h_off)
    );

    dtg_axis_decode #(.CNT_W(PER_W), .PW_W(PW_W), .EXT_W(DIM_W)) u_vdec (
        .cnt     (st_q.vc),
        .sync_m1 (st_q.cfg.v_sw),
        .porch_m1(st_q.cfg.v_bp),
        .ext_m1  (st_q.cfg.act_h),
        .in_sync (v_sync),
        .in_act  (v_win),
        .offset  (v_row)
    );

    // ---------------- field / line mapping ----------------
    logic            il;
    logic [LN_W-1:0] line_full;
    logic            v_act, last_line;
    logic            de_raw, hs_raw, vs_raw;

    always_comb begin
        il        = st_q.cfg.ilace != IL_PROG;
        line_full = il ? {v_row, st_q.field} : {1'b0, v_row};
        v_act     = v_win && (line_full <= {1'b0, st_q.cfg.act_h});
        last_line = (CMP_W'(line_full) + (il ? CMP_W'(2) : CMP_W'(1)))
                    > CMP_W'(st_q.cfg.act_h);
        de_raw    = st_q.run && h_act && v_act;
        hs_raw    = st_q.run && h_sync;
        vs_raw    = st_q.run && v_sync;
    end

    // ---------------- next state ----------------
    logic rise, h_end, v_end, go_on, wrap;

    always_comb begin
        st_d         = st_q;
        st_d.eof     = 1'b0;
        st_d.en_prev = disp_en;
        rise  = disp_en && !st_q.en_prev;
        h_end = st_q.hc == st_q.cfg.h_tot;
        v_end = st_q.vc == st_q.cfg.v_tot;
        go_on = (cont_mode && disp_en) || st_q.req;
        wrap  = st_q.run && pix_ce && h_end && v_end && go_on;

        if (!st_q.run) begin
            if (st_q.req) begin
                st_d.run   = 1'b1;
                st_d.hc    = '0;
                st_d.vc    = '0;
                st_d.cfg   = cfg_in;
                st_d.field = cfg_in.ilace == IL_ODD;
                st_d.req   = 1'b0;
            end
        end else if (pix_ce) begin
            st_d.eof = de_raw && (h_off == st_q.cfg.act_w) && last_line;
            if (h_end) begin
                st_d.hc = '0;
                if (v_end) begin
                    st_d.vc = '0;
                    if (go_on) begin
                        st_d.cfg   = cfg_in;
                        st_d.field = (cfg_in.ilace == IL_ALT) ? !st_q.field
                                                              : (cfg_in.ilace == IL_ODD);
                        st_d.req   = 1'b0;
                    end else begin
                        st_d.run = 1'b0;
                    end
                end else begin
                    st_d.vc = st_q.vc + 1'b1;
                end
            end else begin
                st_d.hc = st_q.hc + 1'b1;
            end
        end
        st_d.req = st_d.req | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- outputs ----------------
    logic [2:0] pin_lvl;

    dtg_out_pol #(.N(3)) u_pol (
        .act      ({de_raw, vs_raw, hs_raw}),
        .act_level(3'b100),
        .inv      ({st_q.cfg.de_inv, st_q.cfg.vs_inv, st_q.cfg.hs_inv}),
        .level    (pin_lvl)
    );

    assign hsync  = pin_lvl[0];
    assign vsync  = pin_lvl[1];
    assign de     = pin_lvl[2];
    assign busy   = st_q.run;
    assign eof    = st_q.eof;
    assign field  = st_q.field;
    assign pix_x  = de_raw ? h_off : '0;
    assign line_y = de_raw ? line_full[DIM_W-1:0] : '0;

    // ---------------- assertions ----------------
    p_eof_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eof |=> !eof);

    p_eof_follows_de_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> $past(de_raw));

    p_hc_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.hc <= st_q.cfg.h_tot));

    p_vs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vs_raw) |-> (st_q.hc == '0 && st_q.vc == '0));

    p_x_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        de_raw |-> (pix_x <= st_q.cfg.act_w));

    p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.run && $past(st_q.run) && !$past(wrap)) |-> $stable(st_q.cfg));
endmodule

// File: tb/disp_timing_gen_bench.sv
module disp_timing_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pix_ce = 1'b1;
    logic        ce_gate = 1'b0;
    logic        disp_en = 1'b0;
    logic        cont_mode = 1'b0;
    logic [10:0] act_w_m1, act_h_m1;
    logic [11:0] h_total_m1, v_total_m1;
    logic [7:0]  h_bp_m1, h_sw_m1, v_bp_m1, v_sw_m1;
    logic        hs_inv = 1'b0, vs_inv = 1'b0, de_inv = 1'b0;
    logic [1:0]  ilace_mode = 2'b00;
    logic        hsync, vsync, de, busy, eof, field;
    logic [10:0] pix_x, line_y;

    int total = 0, bad = 0;
    bit done = 0;

    // per-window statistics
    int n_busy, n_hlo, n_vlo, n_de, n_eof, eof_i, first_i;
    int fx, fy, lx, ly, ymin, ymax, coord_bad, fld0;

    always #10 clk = ~clk;  // 50 MHz

    always @(negedge clk) pix_ce <= ce_gate ? ~pix_ce : 1'b1;

    disp_timing_gen u_disp_timing_gen (
        .clk(clk), .rst_n(rst_n), .pix_ce(pix_ce), .disp_en(disp_en),
        .cont_mode(cont_mode), .act_w_m1(act_w_m1), .act_h_m1(act_h_m1),
        .h_total_m1(h_total_m1), .h_bp_m1(h_bp_m1), .h_sw_m1(h_sw_m1),
        .v_total_m1(v_total_m1), .v_bp_m1(v_bp_m1), .v_sw_m1(v_sw_m1),
        .hs_inv(hs_inv), .vs_inv(vs_inv), .de_inv(de_inv),
        .ilace_mode(ilace_mode), .hsync(hsync), .vsync(vsync), .de(de),
        .busy(busy), .eof(eof), .field(field), .pix_x(pix_x), .line_y(line_y)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_default();
        act_w_m1 = 11'd3;   h_total_m1 = 12'd11; h_sw_m1 = 8'd1; h_bp_m1 = 8'd0;
        act_h_m1 = 11'd2;   v_total_m1 = 12'd6;  v_sw_m1 = 8'd0; v_bp_m1 = 8'd0;
    endtask

    task automatic clear_stats();
        n_busy = 0; n_hlo = 0; n_vlo = 0; n_de = 0; n_eof = 0; eof_i = -1;
        first_i = -1; fx = -1; fy = -1; lx = -1; ly = -1;
        ymin = 9999; ymax = -1; coord_bad = 0; fld0 = field;
    endtask

    task automatic sample(input int i);
        if (busy) n_busy++;
        if (!hsync) n_hlo++;
        if (!vsync) n_vlo++;
        if (de != de_inv) begin
            n_de++;
            if (first_i < 0) begin first_i = i; fx = pix_x; fy = line_y; end
            lx = pix_x; ly = line_y;
            if (int'(line_y) < ymin) ymin = line_y;
            if (int'(line_y) > ymax) ymax = line_y;
        end else if (pix_x != 0 || line_y != 0) begin
            coord_bad++;
        end
        if (eof) begin n_eof++; eof_i = i; end
    endtask

    task automatic collect(input int n);
        for (int i = 0; i < n; i++) begin
            sample(i);
            @(negedge clk);
        end
    endtask

    // returns at the negedge where busy is first seen (slot 0)
    task automatic start_frame();
        @(negedge clk) disp_en = 1'b0;
        @(negedge clk) disp_en = 1'b1;
        for (int w = 0; w < 12 && !busy; w++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(busy == 0, "R1 busy", busy, 0);
        chk(hsync == 1 && vsync == 1, "R1 syncs", {hsync, vsync}, 3);
        chk(de == 0 && eof == 0, "R1 de/eof", {de, eof}, 0);
    endtask

    task automatic t_oneshot();
        start_frame();
        clear_stats();
        collect(84);
        chk(n_busy == 84, "R3 frame length", n_busy, 84);
        chk(n_hlo == 14, "R2 hsync width", n_hlo, 14);
        chk(n_vlo == 12, "R3 vsync lines", n_vlo, 12);
        chk(n_de == 12, "R4 de count", n_de, 12);
        chk(first_i == 27, "R2 R3 first active slot", first_i, 27);
        chk(fx == 0 && fy == 0, "R4 first coord", fx * 100 + fy, 0);
        chk(lx == 3 && ly == 2, "R4 last coord", lx * 100 + ly, 302);
        chk(coord_bad == 0, "R4 coords outside de", coord_bad, 0);
        chk(n_eof == 1, "R6 eof count", n_eof, 1);
        chk(eof_i == 55, "R6 eof slot", eof_i, 55);
        clear_stats();
        collect(20);  // disp_en still held
        chk(n_busy == 0, "R7 one-shot stops", n_busy, 0);
        disp_en = 1'b0;
    endtask

    task automatic t_polarity();
        hs_inv = 1'b1; vs_inv = 1'b1; de_inv = 1'b1;
        start_frame();
        clear_stats();
        collect(84);
        chk(n_hlo == 70, "R5 hsync inverted", n_hlo, 70);
        chk(n_vlo == 72, "R5 vsync inverted", n_vlo, 72);
        chk(n_de == 12, "R5 de inverted active", n_de, 12);
        chk(hsync == 0 && vsync == 0 && de == 1, "R5 idle inverted",
            {hsync, vsync, de}, 1);
        hs_inv = 1'b0; vs_inv = 1'b0; de_inv = 1'b0;
        start_frame();
        clear_stats();
        collect(84);
        chk(n_hlo == 14 && n_de == 12, "R5 restored nominal", n_hlo, 14);
        disp_en = 1'b0;
    endtask

    task automatic t_continuous();
        cont_mode = 1'b1;
        start_frame();
        clear_stats();
        collect(168);
        chk(n_busy == 168, "R8 back-to-back busy", n_busy, 168);
        chk(n_eof == 2 && n_de == 24, "R8 two frames", n_eof * 100 + n_de, 224);
        clear_stats();
        collect(10);
        disp_en = 1'b0;
        collect(74);
        chk(n_busy == 84 && n_eof == 1, "R8 last frame completes", n_busy, 84);
        clear_stats();
        collect(20);
        chk(n_busy == 0, "R8 stops after drop", n_busy, 0);
        cont_mode = 1'b0;
    endtask

    task automatic t_interlace();
        ilace_mode = 2'b10;
        start_frame();
        clear_stats();
        collect(84);
        chk(n_de == 8 && ymin == 0 && ymax == 2, "R9 even field lines", n_de, 8);
        chk(eof_i == 43 && fld0 == 0, "R9 even field eof", eof_i, 43);
        ilace_mode = 2'b11;
        start_frame();
        clear_stats();
        collect(84);
        chk(n_de == 4 && ymin == 1 && ymax == 1, "R9 odd field lines", n_de, 4);
        chk(fld0 == 1, "R9 odd field flag", fld0, 1);
        ilace_mode = 2'b01;
        cont_mode = 1'b1;
        start_frame();
        clear_stats();
        collect(84);
        chk(n_de == 8 && fld0 == 0 && ymax == 2, "R9 alt first field", n_de, 8);
        clear_stats();
        collect(10);
        disp_en = 1'b0;
        collect(74);
        chk(n_de == 4 && fld0 == 1 && ymin == 1, "R9 alt second field", n_de, 4);
        cont_mode = 1'b0;
        ilace_mode = 2'b00;
        collect(4);
    endtask

    task automatic t_midframe();
        cont_mode = 1'b1;
        start_frame();
        clear_stats();
        collect(20);
        act_w_m1 = 11'd1;
        collect(64);
        chk(n_de == 12, "R10 current frame unchanged", n_de, 12);
        clear_stats();
        collect(10);
        disp_en = 1'b0;
        collect(74);
        chk(n_de == 6 && lx == 1, "R10 next frame uses new width", n_de, 6);
        cont_mode = 1'b0;
        cfg_default();
        collect(4);
    endtask

    task automatic t_ce_gated();
        ce_gate = 1'b1;
        @(negedge clk);
        start_frame();
        clear_stats();
        collect(180);
        chk(n_de == 24, "R11 de clocks at half rate", n_de, 24);
        chk(n_busy >= 166 && n_busy <= 168, "R11 frame clocks", n_busy, 168);
        chk(n_eof == 1, "R11 single eof", n_eof, 1);
        disp_en = 1'b0;
        ce_gate = 1'b0;
        collect(4);
    endtask

    initial begin
        cfg_default();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_oneshot();
        t_polarity();
        t_continuous();
        t_interlace();
        t_midframe();
        t_ce_gated();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule